// File: doc/BRIEF.md
# Physical Register Occupancy Tracker

This block keeps count of how many physical registers a rename stage holds in each of several register files. Every architectural register belongs to one file and costs a fixed number of physical registers per definition. Both properties come from a table given as parameters. File 0 is global: every mapping is charged to it, whatever file owns the register.

Each cycle the rename stage may send an allocate request and a free request. Each request carries a list of destination registers with per-destination flags. The block applies the net change to the counters atomically at the clock edge.

An availability query with its own list of destinations is answered combinationally. The answer is a bitmask that names each file that would run out of space if the query's destinations were renamed now.

The requests are plain strobes with no back-pressure. The block has no ready signal: every request offered is taken in the cycle it is offered. The query never blocks allocation. The caller decides whether to stall based on the mask.

Top module: `prf_occupancy_tracker`

## Requirements
- R1: After reset every occupancy counter reads 0, the stall mask is 0 and the underflow flag is low.
- R2: With the default table, register r (a 4-bit index) belongs to file r/4. Registers 8..11 cost 2 and all other registers cost 1. An accepted allocate destination adds its cost to counter 0 and also to its own file's counter when that file is not 0. The counters are visible one cycle after the request.
- R3: An accepted free destination subtracts its cost from the same counters that R2 names.
- R4: A destination whose zero-idiom flag or whose eliminated-move flag is set changes no counter, on either allocate or free.
- R5: A destination whose partial flag is set changes no counter, on either allocate or free. This flag marks a narrow write that is folded into a wider register and leaves the upper bits in place.
- R6: When allocate and free arrive in the same cycle, each counter moves by the net difference. A destination whose valid bit is clear counts for nothing.
- R7: When a counter would drop below zero, it becomes 0 and the underflow flag is high for exactly the following cycle. Counters saturate at 255.
- R8: Stall bit i is high in the same cycle as the query when all of these hold: the query needs n>0 registers in file i, capacity C(i) is less than used(i) plus min(n, C(i)), and C(i) is non-zero. The default capacities are 24, 1, 6 and 0 for files 0 to 3.
- R9: File 3, with capacity 0, never raises its stall bit, however many of its registers are queried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate request strobe |
| alloc_reg | input | NUM_DST*REG_W | Destination register indices, slot d at [d*REG_W +: REG_W] |
| alloc_dst_vld | input | NUM_DST | Slot is in use |
| alloc_zero | input | NUM_DST | Slot is a zero idiom |
| alloc_elim | input | NUM_DST | Slot is an eliminated move |
| alloc_partial | input | NUM_DST | Slot is a partial write folded into a wider register |
| free_valid | input | 1 | Free request strobe |
| free_reg | input | NUM_DST*REG_W | Registers being released |
| free_dst_vld | input | NUM_DST | Slot is in use |
| free_zero | input | NUM_DST | Slot was a zero idiom |
| free_elim | input | NUM_DST | Slot was an eliminated move |
| free_partial | input | NUM_DST | Slot was a folded partial write |
| query_reg | input | NUM_DST*REG_W | Destinations to test for space |
| query_dst_vld | input | NUM_DST | Query slot is in use |
| stall_mask | output | NUM_FILES | Bit i set: file i lacks room for the query |
| used_cnt | output | NUM_FILES*CNT_W | Occupancy of file i at [i*CNT_W +: CNT_W] |
| underflow_err | output | 1 | A counter was clamped at zero on the last update |

## Verification
The hardest cases to reach are the capacity clamp and an underflow that lands in the same edge as an allocation. In the first, one query asks for more registers than a whole file holds. In the second, the counter survives only because the allocation arrives in time. File 1 is given a capacity of 1, so a query naming two of its registers exercises the clamp directly. The random stimulus issues frees more often than the counts warrant and mixes them with allocations in the same cycle, which drives counters to the zero floor repeatedly from several starting levels.

// File: rtl/prt_pkg.sv
package prt_pkg;
  // A destination slot consumes physical registers only if it is in use and
  // none of the bypass conditions applies.
  function automatic logic slot_charges(input logic vld, input logic zero,
                                        input logic elim, input logic partial);
    return vld & ~zero & ~elim & ~partial;
  endfunction
endpackage

// File: rtl/prt_cost_summer.sv
module prt_cost_summer #(
  parameter int NUM_ARCH  = 16,
  parameter int NUM_FILES = 4,
  parameter int NUM_DST   = 2,
  parameter int COST_W    = 2,
  parameter int SUM_W     = 8,
  parameter logic [NUM_ARCH*$clog2(NUM_FILES)-1:0] FILE_MAP = '0,
  parameter logic [NUM_ARCH*COST_W-1:0]            COST_MAP = '0
) (
  input  logic [NUM_DST*$clog2(NUM_ARCH)-1:0] regs_i,
  input  logic [NUM_DST-1:0]                  charge_i,
  output logic [NUM_FILES*SUM_W-1:0]          sums_o
);
  localparam int REG_W  = $clog2(NUM_ARCH);
  localparam int FIDX_W = $clog2(NUM_FILES);

  logic [SUM_W-1:0] acc [NUM_FILES];

  always_comb begin
    for (int f = 0; f < NUM_FILES; f++) acc[f] = '0;
    for (int d = 0; d < NUM_DST; d++) begin
      logic [REG_W-1:0]  r;
      logic [FIDX_W-1:0] fi;
      logic [COST_W-1:0] c;
      r  = regs_i[d*REG_W +: REG_W];
      fi = FILE_MAP[int'(r)*FIDX_W +: FIDX_W];
      c  = COST_MAP[int'(r)*COST_W +: COST_W];
      if (charge_i[d]) begin
        acc[0] = acc[0] + SUM_W'(c);
        if (fi != '0) acc[fi] = acc[fi] + SUM_W'(c);
      end
    end
  end

  for (genvar g = 0; g < NUM_FILES; g++) begin : g_out
    assign sums_o[g*SUM_W +: SUM_W] = acc[g];
  end
endmodule

// File: rtl/prt_counter.sv
module prt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] add_i,
  input  logic [CNT_W-1:0] sub_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uflow_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0]   grown;
  logic [CNT_W:0]   diff;
  logic [CNT_W-1:0] nxt;
  logic             nxt_uf;

  always_comb begin
    grown  = {1'b0, cnt_o} + {1'b0, add_i};
    diff   = grown - {1'b0, sub_i};
    nxt_uf = grown < {1'b0, sub_i};
    if (nxt_uf)       nxt = '0;
    else if (diff[CNT_W]) nxt = CNT_MAX;
    else              nxt = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o   <= '0;
      uflow_o <= 1'b0;
    end else begin
      cnt_o   <= nxt;
      uflow_o <= nxt_uf;
    end
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i == '0 && sub_i == '0) |=> cnt_o == $past(cnt_o));
  p_grow_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_i == '0) |=> cnt_o >= $past(cnt_o));
  p_shrink_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i == '0) |=> cnt_o <= $past(cnt_o));
  p_floor_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |-> ($past(sub_i) != '0 && cnt_o == '0));
endmodule

// File: rtl/prt_stall_eval.sv
module prt_stall_eval #(
  parameter int               CNT_W = 8,
  parameter logic [CNT_W-1:0] CAP   = '0
) (
  input  logic [CNT_W-1:0] used_i,
  input  logic [CNT_W-1:0] req_i,
  output logic             stall_o
);
  if (CAP == '0) begin : g_unbounded
    assign stall_o = 1'b0;
  end else begin : g_bounded
    logic [CNT_W-1:0] req_c;
    logic [CNT_W:0]   need;
    always_comb begin
      req_c   = (req_i > CAP) ? CAP : req_i;
      need    = {1'b0, used_i} + {1'b0, req_c};
      stall_o = (req_i != '0) && (need > {1'b0, CAP});
    end
  end
endmodule

// File: rtl/prf_occupancy_tracker.sv
module prf_occupancy_tracker #(
  parameter int NUM_FILES = 4,
  parameter int NUM_ARCH  = 16,
  parameter int NUM_DST   = 2,
  parameter int CNT_W     = 8,
  parameter int COST_W    = 2,
  parameter logic [NUM_ARCH*$clog2(NUM_FILES)-1:0] FILE_MAP = 32'hFFAA5500,
  parameter logic [NUM_ARCH*COST_W-1:0]            COST_MAP = 32'h55AA5555,
  parameter logic [NUM_FILES*CNT_W-1:0]            CAPS     = 32'h00060118
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                alloc_valid,
  input  logic [NUM_DST*$clog2(NUM_ARCH)-1:0] alloc_reg,
  input  logic [NUM_DST-1:0]                  alloc_dst_vld,
  input  logic [NUM_DST-1:0]                  alloc_zero,
  input  logic [NUM_DST-1:0]                  alloc_elim,
  input  logic [NUM_DST-1:0]                  alloc_partial,
  input  logic                                free_valid,
  input  logic [NUM_DST*$clog2(NUM_ARCH)-1:0] free_reg,
  input  logic [NUM_DST-1:0]                  free_dst_vld,
  input  logic [NUM_DST-1:0]                  free_zero,
  input  logic [NUM_DST-1:0]                  free_elim,
  input  logic [NUM_DST-1:0]                  free_partial,
  input  logic [NUM_DST*$clog2(NUM_ARCH)-1:0] query_reg,
  input  logic [NUM_DST-1:0]                  query_dst_vld,
  output logic [NUM_FILES-1:0]                stall_mask,
  output logic [NUM_FILES*CNT_W-1:0]          used_cnt,
  output logic                                underflow_err
);
  import prt_pkg::*;

  logic [NUM_DST-1:0]         alloc_chg, free_chg;
  logic [NUM_FILES*CNT_W-1:0] add_sum, sub_sum, qry_sum;
  logic [NUM_FILES-1:0]       uf_vec;

  always_comb begin
    for (int d = 0; d < NUM_DST; d++) begin
      alloc_chg[d] = alloc_valid & slot_charges(alloc_dst_vld[d], alloc_zero[d],
                                                alloc_elim[d], alloc_partial[d]);
      free_chg[d]  = free_valid & slot_charges(free_dst_vld[d], free_zero[d],
                                               free_elim[d], free_partial[d]);
    end
  end

  prt_cost_summer #(.NUM_ARCH(NUM_ARCH), .NUM_FILES(NUM_FILES), .NUM_DST(NUM_DST),
    .COST_W(COST_W), .SUM_W(CNT_W), .FILE_MAP(FILE_MAP), .COST_MAP(COST_MAP))
    u_add (.regs_i(alloc_reg), .charge_i(alloc_chg), .sums_o(add_sum));

  prt_cost_summer #(.NUM_ARCH(NUM_ARCH), .NUM_FILES(NUM_FILES), .NUM_DST(NUM_DST),
    .COST_W(COST_W), .SUM_W(CNT_W), .FILE_MAP(FILE_MAP), .COST_MAP(COST_MAP))
    u_sub (.regs_i(free_reg), .charge_i(free_chg), .sums_o(sub_sum));

  prt_cost_summer #(.NUM_ARCH(NUM_ARCH), .NUM_FILES(NUM_FILES), .NUM_DST(NUM_DST),
    .COST_W(COST_W), .SUM_W(CNT_W), .FILE_MAP(FILE_MAP), .COST_MAP(COST_MAP))
    u_qry (.regs_i(query_reg), .charge_i(query_dst_vld), .sums_o(qry_sum));

  for (genvar g = 0; g < NUM_FILES; g++) begin : g_file
    prt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .add_i(add_sum[g*CNT_W +: CNT_W]), .sub_i(sub_sum[g*CNT_W +: CNT_W]),
      .cnt_o(used_cnt[g*CNT_W +: CNT_W]), .uflow_o(uf_vec[g]));

    prt_stall_eval #(.CNT_W(CNT_W), .CAP(CAPS[g*CNT_W +: CNT_W])) u_stall (
      .used_i(used_cnt[g*CNT_W +: CNT_W]), .req_i(qry_sum[g*CNT_W +: CNT_W]),
      .stall_o(stall_mask[g]));

    p_stall_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall_mask[g] |-> qry_sum[g*CNT_W +: CNT_W] != '0);
  end

  assign underflow_err = |uf_vec;

  p_err_needs_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |-> $past(free_valid));
  p_unbounded_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (CAPS[(NUM_FILES-1)*CNT_W +: CNT_W] == '0) |-> !stall_mask[NUM_FILES-1]);
endmodule

// File: tb/prf_occupancy_tracker_tb_top.sv
module prf_occupancy_tracker_tb_top;
  localparam int NF = 4, ND = 2, RW = 4, CW = 8;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          alloc_valid = 0, free_valid = 0;
  logic [ND*RW-1:0] alloc_reg = '0, free_reg = '0, query_reg = '0;
  logic [ND-1:0] alloc_dst_vld = '0, alloc_zero = '0, alloc_elim = '0, alloc_partial = '0;
  logic [ND-1:0] free_dst_vld = '0, free_zero = '0, free_elim = '0, free_partial = '0;
  logic [ND-1:0] query_dst_vld = '0;
  logic [NF-1:0] stall_mask;
  logic [NF*CW-1:0] used_cnt;
  logic underflow_err;

  prf_occupancy_tracker dut_i (.*);

  int checks = 0, errors = 0;
  int model [NF];
  bit model_err;
  int caps [NF] = '{24, 1, 6, 0};

  function automatic int file_of(int r); return r / 4; endfunction
  function automatic int cost_of(int r); return (r / 4 == 2) ? 2 : 1; endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_stall();
    int q [NF];
    int m = 0;
    for (int f = 0; f < NF; f++) q[f] = 0;
    for (int d = 0; d < ND; d++) if (query_dst_vld[d]) begin
      int r = int'(query_reg[d*RW +: RW]);
      q[0] += cost_of(r);
      if (file_of(r) != 0) q[file_of(r)] += cost_of(r);
    end
    for (int f = 0; f < NF; f++)
      if (q[f] > 0 && caps[f] != 0) begin
        int n = (q[f] > caps[f]) ? caps[f] : q[f];
        if (caps[f] < model[f] + n) m |= (1 << f);
      end
    return m;
  endfunction

  task automatic model_update();
    int a [NF];
    int s [NF];
    for (int f = 0; f < NF; f++) begin a[f] = 0; s[f] = 0; end
    for (int d = 0; d < ND; d++) begin
      if (alloc_valid && alloc_dst_vld[d] && !alloc_zero[d] && !alloc_elim[d] && !alloc_partial[d]) begin
        int r = int'(alloc_reg[d*RW +: RW]);
        a[0] += cost_of(r);
        if (file_of(r) != 0) a[file_of(r)] += cost_of(r);
      end
      if (free_valid && free_dst_vld[d] && !free_zero[d] && !free_elim[d] && !free_partial[d]) begin
        int r = int'(free_reg[d*RW +: RW]);
        s[0] += cost_of(r);
        if (file_of(r) != 0) s[file_of(r)] += cost_of(r);
      end
    end
    model_err = 0;
    for (int f = 0; f < NF; f++) begin
      int t = model[f] + a[f];
      if (t < s[f]) begin model[f] = 0; model_err = 1; end
      else model[f] = (t - s[f] > 255) ? 255 : t - s[f];
    end
  endtask

  // inputs already driven at a negedge: check query, clock, check counters
  task automatic step(string req);
    #1;
    chk({req, " stall R8"}, int'(stall_mask), expect_stall());
    @(posedge clk);
    model_update();
    @(negedge clk);
    for (int f = 0; f < NF; f++) chk({req, " used"}, int'(used_cnt[f*CW +: CW]), model[f]);
    chk({req, " underflow R7"}, int'(underflow_err), int'(model_err));
  endtask

  task automatic clear_in();
    alloc_valid = 0; free_valid = 0;
    alloc_dst_vld = '0; alloc_zero = '0; alloc_elim = '0; alloc_partial = '0;
    free_dst_vld = '0; free_zero = '0; free_elim = '0; free_partial = '0;
    query_dst_vld = '0;
  endtask

  task automatic do_alloc(int r0, int r1, logic [1:0] vld);
    clear_in();
    alloc_valid = 1; alloc_dst_vld = vld;
    alloc_reg = {RW'(r1), RW'(r0)};
  endtask

  initial begin
    for (int f = 0; f < NF; f++) model[f] = 0;
    model_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int f = 0; f < NF; f++) chk("R1 reset used", int'(used_cnt[f*CW +: CW]), 0);
    chk("R1 reset stall", int'(stall_mask), 0);
    chk("R1 reset err", int'(underflow_err), 0);

    do_alloc(8, 0, 2'b01); step("R2 file2 cost2");
    do_alloc(5, 2, 2'b11); step("R2 file1 and file0");
    do_alloc(13, 14, 2'b11); alloc_zero = 2'b01; alloc_elim = 2'b10; step("R4 flags on alloc");
    do_alloc(9, 9, 2'b11); alloc_partial = 2'b11; step("R5 partial alloc");
    clear_in(); free_valid = 1; free_dst_vld = 2'b01; free_reg = {RW'(0), RW'(8)};
    free_zero = 2'b00; step("R3 free file2");
    clear_in(); free_valid = 1; free_dst_vld = 2'b11; free_reg = {RW'(12), RW'(4)};
    free_elim = 2'b01; free_partial = 2'b10; step("R4 R5 flags on free");
    do_alloc(10, 0, 2'b01); free_valid = 1; free_dst_vld = 2'b01; free_reg = {RW'(0), RW'(5)};
    step("R6 same-cycle net");
    clear_in(); free_valid = 1; free_dst_vld = 2'b11; free_reg = {RW'(11), RW'(11)};
    step("R7 underflow floor");
    clear_in(); step("R7 err one cycle");
    // clamp: file1 capacity 1, two file1 registers requested, file1 empty
    clear_in(); query_dst_vld = 2'b11; query_reg = {RW'(6), RW'(4)};
    step("R8 clamp to capacity");
    do_alloc(7, 0, 2'b01); step("R2 fill file1");
    clear_in(); query_dst_vld = 2'b01; query_reg = {RW'(0), RW'(4)};
    step("R8 file1 full");
    for (int k = 0; k < 6; k++) begin do_alloc(12, 15, 2'b11); step("R9 fill file3"); end
    clear_in(); query_dst_vld = 2'b11; query_reg = {RW'(13), RW'(14)};
    step("R9 unbounded never stalls");

    void'($urandom(32'h1bad5eed));
    for (int k = 0; k < 400; k++) begin
      clear_in();
      alloc_valid = ($urandom % 10) < 6;
      free_valid  = ($urandom % 10) < 5;
      alloc_reg = ND*RW'($urandom); free_reg = ND*RW'($urandom); query_reg = ND*RW'($urandom);
      alloc_dst_vld = ND'($urandom); free_dst_vld = ND'($urandom); query_dst_vld = ND'($urandom);
      for (int d = 0; d < ND; d++) begin
        alloc_zero[d] = ($urandom % 8) == 0; alloc_elim[d] = ($urandom % 8) == 0;
        alloc_partial[d] = ($urandom % 8) == 0; free_zero[d] = ($urandom % 8) == 0;
        free_elim[d] = ($urandom % 8) == 0; free_partial[d] = ($urandom % 8) == 0;
      end
      step("R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule